// File: doc/BRIEF.md
# Dual-Priority Memory Request Scheduler

This block sits in front of a DRAM controller and reorders incoming memory requests. Every request carries a three-bit warp class describing how well its warp hits in the cache, plus bank, row and column fields. The class steers the request into one of two queues. Warps that hit almost always go to the high queue. All other warps go to the low queue. Each queue has its own backpressure, so a full queue stalls only the requests bound for it.

Each cycle in which the output slot is free or is being emptied, the block chooses one request and loads it into a registered issue port that uses a valid/ready handshake. The low queue is used only when the high queue is empty. Inside a queue, a request whose row is already open in its bank goes first. Among several such requests, the oldest goes first. When no request hits an open row, the oldest request goes. The block keeps one open-row register for each bank and updates it whenever a request is chosen.

Top module: `mds_sched`

## Requirements
- R1: After reset, `issue_valid` is 0, `in_ready` is 1 and no bank has an open row, so the first request chosen for any bank reports `issue_hit` = 0.
- R2: `in_class` encoding: 0 = all-hit and 1 = mostly-hit go to the high queue. 2 = balanced, 3 = mostly-miss and 4 = all-miss go to the low queue, and so do the unused codes 5 to 7. `issue_high` shows which queue the issued request came from.
- R3: A request from the low queue is chosen only when the high queue holds no request at the moment of choice.
- R4: Within a queue, a request whose row equals the open row of its bank is chosen before any request that misses. Among several hits, the earliest accepted is chosen.
- R5: When no entry of the queue hits an open row, the earliest accepted entry of that queue is chosen.
- R6: Choosing a request sets its bank's open row to the request's row. `issue_hit` is 1 exactly when the row was already open in that bank at the moment of choice.
- R7: Each queue holds DEPTH (8) entries. `in_ready` is 0 while the queue addressed by `in_class` is full, and a request offered in that state is not taken.
- R8: A full queue never lowers `in_ready` for a request addressed to the other queue.
- R9: While `issue_valid` is 1 and `issue_ready` is 0, the issue fields hold steady. At most one request leaves per cycle, and a new request is loaded into the issue register in the same cycle the previous one is accepted.
- R10: The order of arrival stays correct after the per-queue arrival counters wrap around, during long runs of continuous traffic.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Addressed queue has room |
| in_class | input | 3 | Warp class of the request |
| in_bank | input | BANK_W | Bank index |
| in_row | input | ROW_W | Row address |
| in_col | input | COL_W | Column address |
| issue_valid | output | 1 | Issue register holds a request |
| issue_ready | input | 1 | DRAM side takes the request |
| issue_bank | output | BANK_W | Issued bank |
| issue_row | output | ROW_W | Issued row |
| issue_col | output | COL_W | Issued column |
| issue_hit | output | 1 | Row was open at the moment of choice |
| issue_high | output | 1 | Request came from the high queue |

## Verification
`in_ready` depends only on the current queue fill and on `in_class`, so it is checked in the same cycle, before the edge, against the fill levels of a queue model. A request accepted at one edge can be chosen at the next edge and shows on the issue port right after that edge. The choice itself looks at the model's queues and open rows as they stood before that edge. The bench therefore updates its model at each rising edge in the same order (choose, then enqueue) and compares every issue output one nanosecond after the edge. Directed sequences hold `issue_ready` low so that entries pile up, then release it. A long mixed run with `issue_ready` toggling drives the arrival counters through several wraps.

// File: rtl/mds_pkg.sv
package mds_pkg;

  typedef enum logic [2:0] {
    WC_ALL_HIT     = 3'd0,
    WC_MOSTLY_HIT  = 3'd1,
    WC_BALANCED    = 3'd2,
    WC_MOSTLY_MISS = 3'd3,
    WC_ALL_MISS    = 3'd4
  } warp_class_e;

  // Classes at or below mostly-hit are served from the high queue.
  function automatic logic class_is_high(input logic [2:0] cls);
    return cls <= WC_MOSTLY_HIT;
  endfunction

endpackage

// File: rtl/mds_open_rows.sv
module mds_open_rows #(
  parameter int BANKS = 4,
  parameter int ROW_W = 8,
  localparam int BANK_W = $clog2(BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              upd,
  input  logic [BANK_W-1:0] upd_bank,
  input  logic [ROW_W-1:0]  upd_row,
  output logic [BANKS-1:0]  open_vld,
  output logic [ROW_W-1:0]  open_row [BANKS]
);

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) begin
        open_vld[b] <= 1'b0;
        open_row[b] <= '0;
      end else if (upd && (upd_bank == BANK_W'(b))) begin
        open_vld[b] <= 1'b1;
        open_row[b] <= upd_row;
      end
    end
  end

endmodule

// File: rtl/mds_queue.sv
module mds_queue #(
  parameter int DEPTH = 8,
  parameter int BANKS = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int SEQ_W = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enq,
  input  logic [BANK_W-1:0] enq_bank,
  input  logic [ROW_W-1:0]  enq_row,
  input  logic [COL_W-1:0]  enq_col,
  input  logic              pop,
  input  logic [BANKS-1:0]  open_vld,
  input  logic [ROW_W-1:0]  open_row [BANKS],
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  level,
  output logic [BANK_W-1:0] sel_bank,
  output logic [ROW_W-1:0]  sel_row,
  output logic [COL_W-1:0]  sel_col,
  output logic              sel_hit
);

  logic [DEPTH-1:0]  vld;
  logic [DEPTH-1:0]  hit_vec;
  logic [BANK_W-1:0] e_bank [DEPTH];
  logic [ROW_W-1:0]  e_row  [DEPTH];
  logic [COL_W-1:0]  e_col  [DEPTH];
  logic [SEQ_W-1:0]  e_seq  [DEPTH];
  logic [SEQ_W-1:0]  next_seq;
  logic [IDX_W-1:0]  free_idx;
  logic [IDX_W-1:0]  best_idx;
  logic              best_hit;
  logic              found;

  // a arrived before b when the wrapped difference is negative
  function automatic logic seq_before(input logic [SEQ_W-1:0] a,
                                      input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] d;
    d = a - b;
    return d[SEQ_W-1];
  endfunction

  always_comb begin
    free_idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--)
      if (!vld[i]) free_idx = IDX_W'(i);
  end

  always_ff @(posedge clk) begin
    if (enq) begin
      e_bank[free_idx] <= enq_bank;
      e_row[free_idx]  <= enq_row;
      e_col[free_idx]  <= enq_col;
      e_seq[free_idx]  <= next_seq;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld      <= '0;
      level    <= '0;
      next_seq <= '0;
    end else begin
      if (pop) vld[best_idx] <= 1'b0;
      if (enq) begin
        vld[free_idx] <= 1'b1;
        next_seq      <= next_seq + 1'b1;
      end
      level <= level + CNT_W'(enq) - CNT_W'(pop);
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_hit
    assign hit_vec[i] = open_vld[e_bank[i]] && (open_row[e_bank[i]] == e_row[i]);
  end

  always_comb begin
    found    = 1'b0;
    best_idx = '0;
    best_hit = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (vld[i]) begin
        if (!found || (hit_vec[i] && !best_hit) ||
            ((hit_vec[i] == best_hit) && seq_before(e_seq[i], e_seq[best_idx]))) begin
          found    = 1'b1;
          best_idx = IDX_W'(i);
          best_hit = hit_vec[i];
        end
      end
    end
  end

  assign full     = (level == CNT_W'(DEPTH));
  assign empty    = (level == '0);
  assign sel_bank = e_bank[best_idx];
  assign sel_row  = e_row[best_idx];
  assign sel_col  = e_col[best_idx];
  assign sel_hit  = best_hit;

endmodule

// File: rtl/mds_sched.sv
module mds_sched
  import mds_pkg::*;
#(
  parameter int BANKS = 4,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  parameter int DEPTH = 8,
  parameter int SEQ_W = 8,
  localparam int BANK_W = $clog2(BANKS),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_class,
  input  logic [BANK_W-1:0] in_bank,
  input  logic [ROW_W-1:0]  in_row,
  input  logic [COL_W-1:0]  in_col,
  output logic              issue_valid,
  input  logic              issue_ready,
  output logic [BANK_W-1:0] issue_bank,
  output logic [ROW_W-1:0]  issue_row,
  output logic [COL_W-1:0]  issue_col,
  output logic              issue_hit,
  output logic              issue_high
);

  localparam int NQ = 2;  // index 0 = high queue, 1 = low queue

  logic              cls_hi;
  logic [NQ-1:0]     q_enq, q_pop, q_full, q_empty, q_hit;
  logic [BANK_W-1:0] q_bank [NQ];
  logic [ROW_W-1:0]  q_row  [NQ];
  logic [COL_W-1:0]  q_col  [NQ];
  logic [CNT_W-1:0]  q_level [NQ];
  logic [BANKS-1:0]  open_vld;
  logic [ROW_W-1:0]  open_row [BANKS];
  logic              out_free, load, pick_lo;

  assign cls_hi   = class_is_high(in_class);
  assign in_ready = cls_hi ? !q_full[0] : !q_full[1];
  assign q_enq[0] = in_valid && cls_hi && !q_full[0];
  assign q_enq[1] = in_valid && !cls_hi && !q_full[1];

  assign out_free = !issue_valid || issue_ready;
  assign pick_lo  = q_empty[0];
  assign load     = out_free && !(&q_empty);
  assign q_pop[0] = load && !pick_lo;
  assign q_pop[1] = load && pick_lo;

  for (genvar q = 0; q < NQ; q++) begin : g_q
    mds_queue #(
      .DEPTH(DEPTH), .BANKS(BANKS), .ROW_W(ROW_W), .COL_W(COL_W), .SEQ_W(SEQ_W)
    ) u_q (
      .clk      (clk),
      .rst      (rst),
      .enq      (q_enq[q]),
      .enq_bank (in_bank),
      .enq_row  (in_row),
      .enq_col  (in_col),
      .pop      (q_pop[q]),
      .open_vld (open_vld),
      .open_row (open_row),
      .full     (q_full[q]),
      .empty    (q_empty[q]),
      .level    (q_level[q]),
      .sel_bank (q_bank[q]),
      .sel_row  (q_row[q]),
      .sel_col  (q_col[q]),
      .sel_hit  (q_hit[q])
    );
  end

  mds_open_rows #(.BANKS(BANKS), .ROW_W(ROW_W)) u_rows (
    .clk      (clk),
    .rst      (rst),
    .upd      (load),
    .upd_bank (q_bank[pick_lo]),
    .upd_row  (q_row[pick_lo]),
    .open_vld (open_vld),
    .open_row (open_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      issue_valid <= 1'b0;
      issue_bank  <= '0;
      issue_row   <= '0;
      issue_col   <= '0;
      issue_hit   <= 1'b0;
      issue_high  <= 1'b0;
    end else if (load) begin
      issue_valid <= 1'b1;
      issue_bank  <= q_bank[pick_lo];
      issue_row   <= q_row[pick_lo];
      issue_col   <= q_col[pick_lo];
      issue_hit   <= q_hit[pick_lo];
      issue_high  <= !pick_lo;
    end else if (issue_ready) begin
      issue_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/mds_sched_chk.sv
module mds_sched_chk #(
  parameter int BANK_W = 2,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int DEPTH  = 8,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_class,
  input logic              issue_valid,
  input logic              issue_ready,
  input logic [BANK_W-1:0] issue_bank,
  input logic [ROW_W-1:0]  issue_row,
  input logic [COL_W-1:0]  issue_col,
  input logic              issue_hit,
  input logic              issue_high,
  input logic              load,
  input logic              hp_empty,
  input logic [CNT_W-1:0]  hp_level,
  input logic [CNT_W-1:0]  lp_level
);

  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !issue_valid);

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (issue_valid && !issue_ready) |=>
      (issue_valid && $stable({issue_bank, issue_row, issue_col, issue_hit, issue_high})));

  // R3
  high_first_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !hp_empty) |=> issue_high);

  // R3
  low_only_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (load && hp_empty) |=> !issue_high);

  // R7
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    (hp_level <= CNT_W'(DEPTH)) && (lp_level <= CNT_W'(DEPTH)));

  // R8
  low_independent_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (in_class >= 3'd2) && (lp_level < CNT_W'(DEPTH))) |-> in_ready);

endmodule

bind mds_sched mds_sched_chk #(
  .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
) u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .in_class    (in_class),
  .issue_valid (issue_valid),
  .issue_ready (issue_ready),
  .issue_bank  (issue_bank),
  .issue_row   (issue_row),
  .issue_col   (issue_col),
  .issue_hit   (issue_hit),
  .issue_high  (issue_high),
  .load        (load),
  .hp_empty    (q_empty[0]),
  .hp_level    (q_level[0]),
  .lp_level    (q_level[1])
);

// File: tb/mds_sched_test.sv
module mds_sched_test;

  localparam int NB = 4;
  localparam int QD = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [2:0] in_class = 3'd0;
  logic [1:0] in_bank = 2'd0;
  logic [7:0] in_row = 8'd0;
  logic [5:0] in_col = 6'd0;
  logic       issue_valid;
  logic       issue_ready = 1'b0;
  logic [1:0] issue_bank;
  logic [7:0] issue_row;
  logic [5:0] issue_col;
  logic       issue_hit;
  logic       issue_high;

  always #2 clk = ~clk;  // 250 MHz

  mds_sched uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_bank(in_bank), .in_row(in_row), .in_col(in_col),
    .issue_valid(issue_valid), .issue_ready(issue_ready), .issue_bank(issue_bank),
    .issue_row(issue_row), .issue_col(issue_col), .issue_hit(issue_hit),
    .issue_high(issue_high)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // model: request code = bank*65536 + row*256 + col, queues kept in arrival order
  int hpq[$];
  int lpq[$];
  int orow [NB];
  bit ovld [NB];
  bit m_ov, m_hit, m_hi;
  int m_code;

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic bit code_hit(input int code);
    int b = code >> 16;
    int r = (code >> 8) & 255;
    return ovld[b] && (orow[b] == r);
  endfunction

  function automatic int pick(input int q[$]);
    foreach (q[i]) if (code_hit(q[i])) return i;
    return 0;
  endfunction

  task automatic cyc(input string tag, input bit v, input int cls, input int b,
                     input int r, input int c, input bit rdy);
    bit exp_rdy, acc;
    int idx;
    in_valid    = v;
    in_class    = 3'(cls);
    in_bank     = 2'(b);
    in_row      = 8'(r);
    in_col      = 6'(c);
    issue_ready = rdy;
    #1;
    exp_rdy = (cls < 2) ? (hpq.size() < QD) : (lpq.size() < QD);
    if (v) check(tag, "in_ready", int'(in_ready), int'(exp_rdy));
    acc = v && exp_rdy;
    @(posedge clk);
    if (!m_ov || rdy) begin
      if (hpq.size() > 0) begin
        idx = pick(hpq); m_code = hpq[idx]; hpq.delete(idx); m_hi = 1; m_ov = 1;
      end else if (lpq.size() > 0) begin
        idx = pick(lpq); m_code = lpq[idx]; lpq.delete(idx); m_hi = 0; m_ov = 1;
      end else begin
        m_ov = 0;
      end
      if (m_ov) begin
        m_hit = code_hit(m_code);
        ovld[m_code >> 16] = 1;
        orow[m_code >> 16] = (m_code >> 8) & 255;
      end
    end
    if (acc) begin
      if (cls < 2) hpq.push_back(b * 65536 + r * 256 + c);
      else         lpq.push_back(b * 65536 + r * 256 + c);
    end
    #1;
    check(tag, "issue_valid", int'(issue_valid), int'(m_ov));
    if (m_ov && issue_valid) begin
      check(tag, "issue code", int'(issue_bank) * 65536 + int'(issue_row) * 256 + int'(issue_col), m_code);
      check(tag, "issue_hit", int'(issue_hit), int'(m_hit));
      check(tag, "issue_high", int'(issue_high), int'(m_hi));
    end
  endtask

  task automatic drain(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not end, got 0 expected 1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) begin ovld[b] = 0; orow[b] = 0; end
    m_ov = 0; m_hit = 0; m_hi = 0; m_code = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    #1;
    // R1: idle after reset, all queues accept
    check("R1", "issue_valid", int'(issue_valid), 0);
    check("R1", "in_ready", int'(in_ready), 1);

    // R2 R3: each class code lands in its queue, high served first
    for (int k = 0; k < 8; k++) cyc("R2 R3", 1, 7 - k, k % NB, 10 + k, k, 0);
    drain("R2 R3", 12);

    // R7 R8 R9: overfill the high queue with issue stalled, low queue still accepts
    for (int k = 0; k < 11; k++) cyc("R7 R9", 1, k % 2, k % NB, 20 + k, k, 0);
    for (int k = 0; k < 3; k++) cyc("R8", 1, 4, k, 40 + k, k, 0);
    cyc("R7", 1, 1, 0, 50, 1, 0);
    drain("R7 R9", 20);

    // R4 R5 R6: hits jump ahead, oldest wins among hits, oldest wins without hits
    cyc("R4 R5 R6", 1, 0, 0, 1, 0, 0);
    cyc("R4 R5 R6", 1, 0, 0, 2, 1, 0);
    cyc("R4 R5 R6", 1, 0, 0, 1, 2, 0);
    cyc("R4 R5 R6", 1, 0, 1, 3, 3, 0);
    cyc("R4 R5 R6", 1, 0, 0, 1, 4, 0);
    cyc("R4 R5 R6", 1, 3, 2, 7, 5, 0);
    cyc("R4 R5 R6", 1, 3, 2, 8, 6, 0);
    cyc("R4 R5 R6", 1, 2, 2, 7, 7, 0);
    drain("R4 R5 R6", 14);

    // R10 with R3 R4 R6 R9: long mixed traffic, arrival counters wrap many times
    begin
      int unsigned s = 32'h1234_5678;
      for (int k = 0; k < 6000; k++) begin
        s = s * 1103515245 + 12345;
        cyc("R10", s[16] | s[17], int'(s[20:18]), int'(s[22:21]), int'(s[24:23]),
            int'(s[30:25]), s[26] | s[27] | s[28]);
      end
    end
    drain("R10", 40);

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule